// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Tag Array

This block holds the tags and valid bits for a 2-way, 256-set, 64-byte-line data cache (32 KB of data held elsewhere). The set index is taken from the virtual address, so a lookup can start while the address is still being translated. The translated physical frame number then arrives in the same cycle and is compared in full against both ways. Address bits 11:0 are untranslated. Index bits 13:12 lie above the page boundary, so one physical line could be placed in any of four sets.

To keep each physical line in the cache at most once, a fill first scans the four candidate sets that share its page-offset index bits. It invalidates any way holding the same physical tag, and only then writes the new line. A coherence snoop carries only a physical address, so it also probes all four candidate sets, both ways in each, and invalidates whatever matches. Scans run one candidate set per cycle. While a scan or a fill write is in progress, `busy` is high and lookups are not accepted. Replacement uses one LRU bit per set.

Top module: `vipt_tag_array`

## Requirements
- R1: After reset every line is invalid: `busy`, `fill_done` and `snp_done` are 0, and any lookup misses.
- R2: A lookup uses set `lk_va[13:6]` and compares `lk_ptag` (physical address bits 40:12, 29 bits) with every valid way. The result appears on `lk_resp_valid`/`lk_resp_hit`/`lk_resp_way` one cycle after acceptance. A hit needs all 29 tag bits to be equal.
- R3: A lookup is accepted only in an idle cycle with no fill or snoop request. A lookup offered while `busy` is high gets no response, and it is accepted in the first idle cycle.
- R4: A fill probes sets `{k, fill_va[11:6]}` for k = 0..3 and invalidates any way whose tag equals `fill_ptag`. It then writes the line into set `fill_va[13:6]`, so a physical line is present at most once.
- R5: The fill victim is the lowest-numbered invalid way, or the LRU way if both are valid. `fill_done` pulses for one cycle with the chosen way on `fill_way`.
- R6: Each set keeps one LRU bit. A lookup hit or a fill write to way w makes the other way the next victim.
- R7: A snoop probes sets `{k, snp_pa[11:6]}` for k = 0..3, both ways each, and invalidates any way whose tag equals `snp_pa[40:12]`. `snp_done` pulses with `snp_hit` = 1 if anything was invalidated. Other lines are untouched.
- R8: After the accepting edge, `busy` stays high for exactly 4 cycles for a snoop and 5 cycles for a fill. The done pulse appears in the first cycle `busy` is low again.
- R9: When requests meet in one idle cycle, the snoop wins over the fill and the fill wins over the lookup. A losing request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 14 | Virtual address bits 13:0 of the lookup |
| lk_ptag | input | 29 | Translated physical tag (PA 40:12) |
| lk_resp_valid | output | 1 | Lookup result valid |
| lk_resp_hit | output | 1 | Lookup hit |
| lk_resp_way | output | 1 | Way that hit |
| fill_valid | input | 1 | Fill request |
| fill_va | input | 14 | Virtual address bits 13:0 of the fill |
| fill_ptag | input | 29 | Physical tag of the filled line |
| fill_done | output | 1 | Fill written (one-cycle pulse) |
| fill_way | output | 1 | Way the fill used |
| snp_valid | input | 1 | Snoop request |
| snp_pa | input | 41 | Physical address of the snoop |
| snp_done | output | 1 | Snoop finished (one-cycle pulse) |
| snp_hit | output | 1 | Snoop invalidated a line |
| busy | output | 1 | Scan or fill write in progress |

## Verification
A snoop and a lookup, or a snoop and a fill, can be requested in the same idle cycle. The bench drives both on one falling edge. For the snoop and lookup pair, it judges that no lookup response follows and that the snoop completes normally. For the snoop and fill pair, it judges that `busy` lasts only the 4 snoop cycles and that the fill's line is absent afterwards. A lookup held high through a busy period must produce no response until the first idle cycle, and then produce the correct hit.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // geometry; WAYS is fixed at 2 by the single-bit LRU
  parameter int OFF_W  = 6;
  parameter int IDX_W  = 8;
  parameter int PAGE_W = 12;
  parameter int PA_W   = 41;
  parameter int WAYS   = 2;

  localparam int VA_W    = OFF_W + IDX_W;
  localparam int TAG_W   = PA_W - PAGE_W;
  localparam int ALIAS_W = VA_W - PAGE_W;
  localparam int N_CAND  = 1 << ALIAS_W;
  localparam int LOW_W   = IDX_W - ALIAS_W;
  localparam int SETS    = 1 << IDX_W;
  localparam int WAY_W   = $clog2(WAYS);

  typedef logic [IDX_W-1:0]              idx_t;
  typedef logic [TAG_W-1:0]              tag_t;
  typedef logic [LOW_W-1:0]              low_t;
  typedef logic [ALIAS_W-1:0]            alias_t;
  typedef logic [WAY_W-1:0]              way_t;
  typedef logic [WAYS-1:0]               way_mask_t;
  typedef logic [WAYS-1:0][TAG_W-1:0]    tag_row_t;
  typedef logic [VA_W-1:0]               va_t;
  typedef logic [PA_W-1:0]               pa_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WRITE} state_e;
  typedef enum logic {OP_FILL, OP_SNOOP} op_e;

  function automatic idx_t va_set(va_t va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic low_t va_low(va_t va);
    return va[PAGE_W-1:OFF_W];
  endfunction

  function automatic low_t pa_low(pa_t pa);
    return pa[PAGE_W-1:OFF_W];
  endfunction

  function automatic tag_t pa_tag(pa_t pa);
    return pa[PA_W-1:PAGE_W];
  endfunction

  function automatic idx_t cand_set(alias_t k, low_t low);
    return {k, low};
  endfunction

  function automatic way_mask_t tag_match(way_mask_t vld, tag_row_t row, tag_t want);
    way_mask_t m;
    for (int w = 0; w < WAYS; w++) m[w] = vld[w] && (row[w] == want);
    return m;
  endfunction

  function automatic way_t first_way(way_mask_t m);
    way_t r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (m[w]) r = way_t'(w);
    return r;
  endfunction

  function automatic way_t pick_victim(way_mask_t vld, way_t lru);
    way_t r = lru;
    logic found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[w]) begin
        r = way_t'(w);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic way_mask_t way_onehot(way_t w);
    way_mask_t m = '0;
    m[w] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
  import vipt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  idx_t      rd_idx,
  output way_mask_t rd_valid,
  output tag_row_t  rd_tags,
  input  logic      wr_en,
  input  idx_t      wr_idx,
  input  way_mask_t wr_mask,
  input  logic      wr_set_valid,
  input  tag_t      wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vld_q;
    tag_t            tag_q [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '0;
      else if (wr_en && wr_mask[w]) vld_q[wr_idx] <= wr_set_valid;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[w] && wr_set_valid) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid[w] = vld_q[rd_idx];
    assign rd_tags[w]  = tag_q[rd_idx];
  end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru
  import vipt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t rd_idx,
  output way_t rd_lru,
  input  logic upd_en,
  input  idx_t upd_idx,
  input  way_t upd_used
);
  way_t lru_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (upd_en) begin
      lru_q[upd_idx] <= ~upd_used;
    end
  end

  assign rd_lru = lru_q[rd_idx];

  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (lru_q[$past(upd_idx)] != $past(upd_used))); // R6
endmodule

// File: rtl/vipt_scan_ctrl.sv
module vipt_scan_ctrl
  import vipt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_fill,
  input  logic      req_snoop,
  input  va_t       fill_va,
  input  tag_t      fill_tag,
  input  pa_t       snoop_pa,
  input  way_mask_t probe_hits,
  output state_e    state,
  output idx_t      probe_idx,
  output idx_t      hold_set,
  output tag_t      hold_tag,
  output logic      fill_done,
  output logic      snp_done,
  output logic      snp_hit
);
  state_e state_q;
  op_e    op_q;
  alias_t cand_q;
  low_t   low_q;
  logic   any_q;
  logic   last_cand;

  assign last_cand = (cand_q == alias_t'(N_CAND - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_FILL;
      cand_q    <= '0;
      low_q     <= '0;
      any_q     <= 1'b0;
      hold_set  <= '0;
      hold_tag  <= '0;
      fill_done <= 1'b0;
      snp_done  <= 1'b0;
      snp_hit   <= 1'b0;
    end else begin
      fill_done <= 1'b0;
      snp_done  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cand_q <= '0;
          any_q  <= 1'b0;
          if (req_snoop) begin
            op_q     <= OP_SNOOP;
            low_q    <= pa_low(snoop_pa);
            hold_tag <= pa_tag(snoop_pa);
            state_q  <= ST_SCAN;
          end else if (req_fill) begin
            op_q     <= OP_FILL;
            low_q    <= va_low(fill_va);
            hold_set <= va_set(fill_va);
            hold_tag <= fill_tag;
            state_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          any_q  <= any_q | (|probe_hits);
          cand_q <= cand_q + alias_t'(1);
          if (last_cand) begin
            if (op_q == OP_FILL) begin
              state_q <= ST_WRITE;
            end else begin
              state_q  <= ST_IDLE;
              snp_done <= 1'b1;
              snp_hit  <= any_q | (|probe_hits);
            end
          end
        end
        ST_WRITE: begin
          state_q   <= ST_IDLE;
          fill_done <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign probe_idx = cand_set(cand_q, low_q);

  AST_SCAN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_SCAN) || (cand_q == '0)); // R4
endmodule

// File: rtl/vipt_tag_array.sv
module vipt_tag_array
  import vipt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [TAG_W-1:0]   lk_ptag,
  output logic               lk_resp_valid,
  output logic               lk_resp_hit,
  output logic [WAY_W-1:0]   lk_resp_way,
  input  logic               fill_valid,
  input  logic [VA_W-1:0]    fill_va,
  input  logic [TAG_W-1:0]   fill_ptag,
  output logic               fill_done,
  output logic [WAY_W-1:0]   fill_way,
  input  logic               snp_valid,
  input  logic [PA_W-1:0]    snp_pa,
  output logic               snp_done,
  output logic               snp_hit,
  output logic               busy
);
  state_e    state;
  idx_t      probe_idx, hold_set, rd_idx;
  tag_t      hold_tag;
  way_mask_t rd_valid, probe_hits, lk_match;
  tag_row_t  rd_tags;
  way_t      rd_lru, victim;
  logic      idle, lk_accept, lk_hit_now;
  logic      wr_en, wr_set_valid;
  idx_t      wr_idx;
  way_mask_t wr_mask;
  logic      lru_upd;
  idx_t      lru_idx;
  way_t      lru_used;

  assign idle = (state == ST_IDLE);
  assign busy = !idle;

  // event wires
  assign lk_accept  = idle && lk_valid && !snp_valid && !fill_valid;
  assign lk_match   = tag_match(rd_valid, rd_tags, lk_ptag);
  assign lk_hit_now = lk_accept && (|lk_match);
  assign probe_hits = (state == ST_SCAN) ? tag_match(rd_valid, rd_tags, hold_tag) : '0;
  assign victim     = pick_victim(rd_valid, rd_lru);

  always_comb begin
    unique case (state)
      ST_SCAN:  rd_idx = probe_idx;
      ST_WRITE: rd_idx = hold_set;
      default:  rd_idx = va_set(lk_va);
    endcase
  end

  always_comb begin
    wr_en        = 1'b0;
    wr_idx       = probe_idx;
    wr_mask      = probe_hits;
    wr_set_valid = 1'b0;
    if (state == ST_SCAN && (|probe_hits)) begin
      wr_en = 1'b1;
    end else if (state == ST_WRITE) begin
      wr_en        = 1'b1;
      wr_idx       = hold_set;
      wr_mask      = way_onehot(victim);
      wr_set_valid = 1'b1;
    end
  end

  always_comb begin
    lru_upd  = lk_hit_now || (state == ST_WRITE);
    lru_idx  = (state == ST_WRITE) ? hold_set : va_set(lk_va);
    lru_used = (state == ST_WRITE) ? victim : first_way(lk_match);
  end

  vipt_tag_store u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tags(rd_tags),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_set_valid(wr_set_valid), .wr_tag(hold_tag)
  );

  vipt_lru u_lru (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_lru(rd_lru),
    .upd_en(lru_upd), .upd_idx(lru_idx), .upd_used(lru_used)
  );

  vipt_scan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_fill(fill_valid), .req_snoop(snp_valid),
    .fill_va(fill_va), .fill_tag(fill_ptag), .snoop_pa(snp_pa),
    .probe_hits(probe_hits), .state(state), .probe_idx(probe_idx),
    .hold_set(hold_set), .hold_tag(hold_tag),
    .fill_done(fill_done), .snp_done(snp_done), .snp_hit(snp_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_resp_valid <= 1'b0;
      lk_resp_hit   <= 1'b0;
      lk_resp_way   <= '0;
      fill_way      <= '0;
    end else begin
      lk_resp_valid <= lk_accept;
      lk_resp_hit   <= lk_hit_now;
      lk_resp_way   <= first_way(lk_match);
      if (state == ST_WRITE) fill_way <= victim;
    end
  end

  AST_PROBE_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_hits)); // R4
  AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_resp_hit |-> lk_resp_valid); // R2
  AST_BUSY_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !lk_resp_valid); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done || snp_done) |-> (!busy && $past(busy))); // R8
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_done && snp_done)); // R8
  AST_SNOOP_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && snp_valid) |=> busy ##4 (snp_done && !fill_done)); // R9
endmodule

// File: tb/vipt_tag_array_bench.sv
module vipt_tag_array_bench;
  import vipt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, snp_valid = 1'b0;
  logic [VA_W-1:0]  lk_va = '0, fill_va = '0;
  logic [TAG_W-1:0] lk_ptag = '0, fill_ptag = '0;
  logic [PA_W-1:0]  snp_pa = '0;
  logic lk_resp_valid, lk_resp_hit, fill_done, snp_done, snp_hit, busy;
  logic [WAY_W-1:0] lk_resp_way, fill_way;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vipt_tag_array u_vipt_tag_array (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mk_va(input logic [1:0] al, input logic [5:0] low);
    return {al, low, 6'h2A};
  endfunction

  function automatic logic [PA_W-1:0] mk_pa(input logic [TAG_W-1:0] t, input logic [5:0] low);
    return {t, low, 6'h11};
  endfunction

  task automatic lookup(input logic [VA_W-1:0] va, input logic [TAG_W-1:0] t,
                        output logic v, output logic h, output logic w);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_ptag = t;
    @(negedge clk);
    lk_valid = 1'b0;
    v = lk_resp_valid; h = lk_resp_hit; w = lk_resp_way;
  endtask

  task automatic expect_lookup(input string req, input logic [VA_W-1:0] va,
                               input logic [TAG_W-1:0] t, input logic eh, input logic ew);
    logic v, h, w;
    lookup(va, t, v, h, w);
    chk(req, "lookup valid", v, 1);
    chk(req, "lookup hit", h, eh);
    if (eh) chk(req, "lookup way", w, ew);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_fill(input logic [VA_W-1:0] va, input logic [TAG_W-1:0] t, input logic ew);
    int n;
    @(negedge clk);
    fill_valid = 1'b1; fill_va = va; fill_ptag = t;
    @(negedge clk);
    fill_valid = 1'b0;
    wait_idle(n);
    chk("R8", "fill busy cycles", n, 5);
    chk("R5", "fill_done", fill_done, 1);
    chk("R5", "fill_way", fill_way, ew);
  endtask

  task automatic do_snoop(input logic [PA_W-1:0] pa, input logic eh);
    int n;
    @(negedge clk);
    snp_valid = 1'b1; snp_pa = pa;
    @(negedge clk);
    snp_valid = 1'b0;
    wait_idle(n);
    chk("R8", "snoop busy cycles", n, 4);
    chk("R7", "snp_done", snp_done, 1);
    chk("R7", "snp_hit", snp_hit, eh);
  endtask

  localparam logic [TAG_W-1:0] T1 = 29'h0ABCDE1;
  localparam logic [TAG_W-1:0] T2 = 29'h1234567;
  localparam logic [TAG_W-1:0] T3 = 29'h0765432;
  localparam logic [TAG_W-1:0] T4 = 29'h1000002;
  localparam logic [TAG_W-1:0] T5 = 29'h0F0F0F3;
  localparam logic [TAG_W-1:0] T6 = 29'h0333330;
  localparam logic [TAG_W-1:0] T7 = 29'h1555555;

  task automatic t_reset();
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "fill_done after reset", fill_done, 0);
    chk("R1", "snp_done after reset", snp_done, 0);
    expect_lookup("R1", mk_va(2'd0, 6'd0), '0, 1'b0, 1'b0);
    expect_lookup("R1", mk_va(2'd3, 6'd63), T7, 1'b0, 1'b0);
  endtask

  task automatic t_fill_hit();
    do_fill(mk_va(2'd1, 6'd5), T1, 1'b0);
    expect_lookup("R2", mk_va(2'd1, 6'd5), T1, 1'b1, 1'b0);
    expect_lookup("R2", mk_va(2'd1, 6'd5), T1 ^ 29'h1000_0000, 1'b0, 1'b0);
    expect_lookup("R2", mk_va(2'd2, 6'd5), T1, 1'b0, 1'b0);
  endtask

  task automatic t_alias();
    do_fill(mk_va(2'd2, 6'd5), T1, 1'b0);
    expect_lookup("R4", mk_va(2'd1, 6'd5), T1, 1'b0, 1'b0);
    expect_lookup("R4", mk_va(2'd2, 6'd5), T1, 1'b1, 1'b0);
  endtask

  task automatic t_lru();
    do_fill(mk_va(2'd0, 6'd9), T2, 1'b0);
    do_fill(mk_va(2'd0, 6'd9), T3, 1'b1);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T2, 1'b1, 1'b0);
    do_fill(mk_va(2'd0, 6'd9), T4, 1'b1);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T3, 1'b0, 1'b0);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T2, 1'b1, 1'b0);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T4, 1'b1, 1'b1);
    do_fill(mk_va(2'd0, 6'd9), T5, 1'b0);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T2, 1'b0, 1'b0);
    expect_lookup("R6", mk_va(2'd0, 6'd9), T4, 1'b1, 1'b1);
  endtask

  task automatic t_snoop();
    do_snoop(mk_pa(T1, 6'd5), 1'b1);
    expect_lookup("R7", mk_va(2'd2, 6'd5), T1, 1'b0, 1'b0);
    do_snoop(mk_pa(T1, 6'd5), 1'b0);
    do_snoop(mk_pa(T4, 6'd9), 1'b1);
    expect_lookup("R7", mk_va(2'd0, 6'd9), T4, 1'b0, 1'b0);
    expect_lookup("R7", mk_va(2'd0, 6'd9), T5, 1'b1, 1'b0);
  endtask

  task automatic t_busy_lookup();
    int n;
    @(negedge clk);
    snp_valid = 1'b1; snp_pa = mk_pa(T7, 6'd40);
    @(negedge clk);
    snp_valid = 1'b0;
    lk_valid = 1'b1; lk_va = mk_va(2'd0, 6'd9); lk_ptag = T5;
    n = 0;
    while (busy && n < 20) begin
      @(negedge clk);
      n++;
      chk("R3", "no response while busy", lk_resp_valid, 0);
    end
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R3", "response once idle", lk_resp_valid, 1);
    chk("R3", "hit once idle", lk_resp_hit, 1);
  endtask

  task automatic t_collide();
    int n;
    // snoop and lookup in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_pa = mk_pa(T7, 6'd41);
    lk_valid = 1'b1; lk_va = mk_va(2'd0, 6'd9); lk_ptag = T5;
    @(negedge clk);
    snp_valid = 1'b0; lk_valid = 1'b0;
    chk("R9", "lookup dropped vs snoop", lk_resp_valid, 0);
    chk("R9", "snoop taken", busy, 1);
    wait_idle(n);
    chk("R9", "snoop done", snp_done, 1);
    // snoop and fill in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_pa = mk_pa(T7, 6'd20);
    fill_valid = 1'b1; fill_va = mk_va(2'd3, 6'd20); fill_ptag = T6;
    @(negedge clk);
    snp_valid = 1'b0; fill_valid = 1'b0;
    wait_idle(n);
    chk("R9", "busy cycles of winning snoop", n, 4);
    chk("R9", "fill_done absent", fill_done, 0);
    expect_lookup("R9", mk_va(2'd3, 6'd20), T6, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_alias();
    t_lru();
    t_snoop();
    t_busy_lookup();
    t_collide();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule